// File: doc/BRIEF.md
# SRAM-Backed Local-Bus FIFO Controller

This block turns a single-port synchronous SRAM of 32-bit words into a deep first-in first-out buffer. The buffer is reached through a local bus that carries one beat per clock. One address bit splits the bus space into two windows. The upper window is the FIFO data port, and every address inside it reaches the same port. The lower window holds a small set of control and status words, selected by four low address bits.

The block drives the SRAM address, write strobe and output enable straight from the decoded beat. It keeps the write pointer, the read pointer and an occupancy count. Every beat is acknowledged exactly one clock after it is presented. A host can therefore stream writes or reads with no gaps. A beat that would overrun a full buffer, or underrun an empty one, is still acknowledged, but it leaves the SRAM and the FIFO state untouched. Empty, full and the occupancy count are also driven on dedicated outputs for downstream logic.

Top module: `lbus_sram_fifo`

## Requirements
- R1: A beat whose address bit 22 is 0 is a register access and drives neither `sram_we_o` nor `sram_oe_o`. A beat with bit 22 set is a FIFO access.
- R2: For FIFO beats, address bits 21 down to 0 are ignored. Writes and reads at different addresses in the FIFO window all use the same queue.
- R3: Each beat presented with `lb_req_i` high is acknowledged on `lb_ack_o` in the following cycle. Consecutive beats are acknowledged back to back. `lb_ack_o` stays low in the cycle after a clock without a request.
- R4: A FIFO write while not full asserts `sram_we_o` in the same cycle, with `sram_wdata_o` equal to the bus data. It then advances the write pointer and raises the count by one.
- R5: A FIFO read while not empty asserts `sram_oe_o` in the same cycle. The oldest stored word appears on `lb_rdata_o` with the acknowledge, and the count drops by one.
- R6: A FIFO write while full produces no SRAM write and leaves the count and stored contents unchanged.
- R7: A FIFO read while empty produces no SRAM enable, returns 0, and leaves the count unchanged.
- R8: A read of register index 0 (address bits 5:2 = 0) returns the status word: the count in the low bits, full in bit 30 and empty in bit 31. Other register indices read as 0.
- R9: A write to register index 1 with data bit 0 set empties the FIFO. With bit 0 clear, or to any other index, the write has no effect on the FIFO.
- R10: Pointers wrap modulo the depth, and data order is kept across the wrap.
- R11: After reset the FIFO is empty with count 0, and `lb_ack_o` is low.
- R12: `sram_we_o` and `sram_oe_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lb_req_i | input | 1 | Beat present this cycle |
| lb_wr_i | input | 1 | 1 = write beat, 0 = read beat |
| lb_addr_i | input | LA_W | Byte address of the beat |
| lb_wdata_i | input | DATA_W | Write data of the beat |
| lb_ack_o | output | 1 | Acknowledge, one cycle after the beat |
| lb_rdata_o | output | DATA_W | Read data, valid with the acknowledge |
| sram_addr_o | output | MEM_AW | SRAM word address |
| sram_wdata_o | output | DATA_W | SRAM write data |
| sram_we_o | output | 1 | SRAM write strobe |
| sram_oe_o | output | 1 | SRAM read enable (data returned next cycle) |
| sram_rdata_i | input | DATA_W | SRAM read data |
| fifo_count_o | output | PTR_W+1 | Occupancy count |
| fifo_empty_o | output | 1 | FIFO empty |
| fifo_full_o | output | 1 | FIFO full |

## Verification
Directed sequences fill the FIFO through scattered window addresses, push one extra word, read the status word, then drain past empty. This separates address aliasing, overrun holding and underrun holding. A write-drain-write sequence crosses the pointer wrap and shows whether order survives it. Register writes with the clear bit set and cleared tell a real clear from a stray effect. A long seeded random mix of FIFO writes, reads, status reads, idle cycles and rare clears follows. Every beat is checked against a queue model for acknowledge timing, SRAM strobes, returned data and count, which catches off-by-one and same-cycle hazards that the directed cases miss.

// File: rtl/lbf_pkg.sv
package lbf_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_CSR  = 2'd1,
        ACC_FIFO = 2'd2
    } acc_e;

    // register window word indices
    localparam int CSR_STATUS_IDX = 0;
    localparam int CSR_CTRL_IDX   = 1;
    // control word bit that empties the buffer
    localparam int CTRL_CLEAR_BIT = 0;
endpackage

// File: rtl/lbf_decode.sv
module lbf_decode
    import lbf_pkg::*;
#(
    parameter int LA_W    = 23,
    parameter int SEL_BIT = 22,
    parameter int IDX_LO  = 2,
    parameter int IDX_HI  = 5
) (
    input  logic                     req_i,
    input  logic [LA_W-1:0]          addr_i,
    output acc_e                     acc_o,
    output logic [IDX_HI-IDX_LO:0]   idx_o
);
    // bits outside the window select and the register index are don't-care
    logic unused_addr_bits;
    assign unused_addr_bits = ^addr_i;

    always_comb begin
        acc_o = ACC_IDLE;
        if (req_i) begin
            acc_o = addr_i[SEL_BIT] ? ACC_FIFO : ACC_CSR;
        end
        idx_o = addr_i[IDX_HI:IDX_LO];
    end
endmodule

// File: rtl/lbf_state.sv
module lbf_state #(
    parameter int PTR_W = 17
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             clear_i,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic [PTR_W:0]   count_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             push_ok_o,
    output logic             pop_ok_o
);
    localparam int COUNT_W = PTR_W + 1;
    localparam int DEPTH   = 1 << PTR_W;

    typedef struct packed {
        logic [PTR_W-1:0]   wr_ptr;
        logic [PTR_W-1:0]   rd_ptr;
        logic [COUNT_W-1:0] count;
    } fst_t;

    fst_t st_d, st_q;
    logic push_ok, pop_ok, empty, full;

    always_comb begin
        empty   = (st_q.count == '0);
        full    = st_q.count[PTR_W];
        push_ok = push_i && !full;
        pop_ok  = pop_i && !empty;
        st_d    = st_q;
        if (clear_i) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wr_ptr = st_q.wr_ptr + PTR_W'(1);
            if (pop_ok)  st_d.rd_ptr = st_q.rd_ptr + PTR_W'(1);
            case ({push_ok, pop_ok})
                2'b10:   st_d.count = st_q.count + COUNT_W'(1);
                2'b01:   st_d.count = st_q.count - COUNT_W'(1);
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign wr_ptr_o  = st_q.wr_ptr;
    assign rd_ptr_o  = st_q.rd_ptr;
    assign count_o   = st_q.count;
    assign empty_o   = empty;
    assign full_o    = full;
    assign push_ok_o = push_ok;
    assign pop_ok_o  = pop_ok;

    // R4
    count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.count <= COUNT_W'(DEPTH));

    // R6
    no_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full && push_i && !pop_i && !clear_i) |=> ($stable(st_q.count) && $stable(st_q.wr_ptr)));

    // R7
    no_underrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (empty && pop_i && !push_i && !clear_i) |=> ($stable(st_q.count) && $stable(st_q.rd_ptr)));

    // R9
    clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (st_q.count == '0 && st_q.wr_ptr == st_q.rd_ptr));
endmodule

// File: rtl/lbus_sram_fifo.sv
module lbus_sram_fifo
    import lbf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PTR_W   = 17,
    parameter int MEM_AW  = 18,
    parameter int LA_W    = 23,
    parameter int SEL_BIT = 22,
    parameter int IDX_LO  = 2,
    parameter int IDX_HI  = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              lb_req_i,
    input  logic              lb_wr_i,
    input  logic [LA_W-1:0]   lb_addr_i,
    input  logic [DATA_W-1:0] lb_wdata_i,
    output logic              lb_ack_o,
    output logic [DATA_W-1:0] lb_rdata_o,
    output logic [MEM_AW-1:0] sram_addr_o,
    output logic [DATA_W-1:0] sram_wdata_o,
    output logic              sram_we_o,
    output logic              sram_oe_o,
    input  logic [DATA_W-1:0] sram_rdata_i,
    output logic [PTR_W:0]    fifo_count_o,
    output logic              fifo_empty_o,
    output logic              fifo_full_o
);
    localparam int IDX_W   = IDX_HI - IDX_LO + 1;
    localparam int COUNT_W = PTR_W + 1;

    typedef struct packed {
        logic              ack;
        logic              from_sram;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    acc_e             acc;
    logic [IDX_W-1:0] idx;
    logic             push, pop, clear;
    logic             push_ok, pop_ok, empty, full;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W:0]   count;
    logic [DATA_W-1:0] status_word;
    rsp_t rsp_d, rsp_q;

    lbf_decode #(
        .LA_W(LA_W), .SEL_BIT(SEL_BIT), .IDX_LO(IDX_LO), .IDX_HI(IDX_HI)
    ) decode_i (
        .req_i (lb_req_i),
        .addr_i(lb_addr_i),
        .acc_o (acc),
        .idx_o (idx)
    );

    lbf_state #(.PTR_W(PTR_W)) state_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .push_i   (push),
        .pop_i    (pop),
        .clear_i  (clear),
        .wr_ptr_o (wr_ptr),
        .rd_ptr_o (rd_ptr),
        .count_o  (count),
        .empty_o  (empty),
        .full_o   (full),
        .push_ok_o(push_ok),
        .pop_ok_o (pop_ok)
    );

    always_comb begin
        push  = (acc == ACC_FIFO) && lb_wr_i;
        pop   = (acc == ACC_FIFO) && !lb_wr_i;
        clear = (acc == ACC_CSR) && lb_wr_i && (idx == IDX_W'(CSR_CTRL_IDX))
                && lb_wdata_i[CTRL_CLEAR_BIT];

        status_word             = '0;
        status_word[COUNT_W-1:0] = count;
        status_word[DATA_W-2]   = full;
        status_word[DATA_W-1]   = empty;

        sram_addr_o  = pop ? MEM_AW'(rd_ptr) : MEM_AW'(wr_ptr);
        sram_wdata_o = lb_wdata_i;
        sram_we_o    = push_ok;
        sram_oe_o    = pop_ok;

        rsp_d.ack       = lb_req_i;
        rsp_d.from_sram = pop_ok;
        rsp_d.rdata     = '0;
        if ((acc == ACC_CSR) && !lb_wr_i && (idx == IDX_W'(CSR_STATUS_IDX))) begin
            rsp_d.rdata = status_word;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rsp_q <= '0;
        else         rsp_q <= rsp_d;
    end

    assign lb_ack_o     = rsp_q.ack;
    assign lb_rdata_o   = rsp_q.from_sram ? sram_rdata_i : rsp_q.rdata;
    assign fifo_count_o = count;
    assign fifo_empty_o = empty;
    assign fifo_full_o  = full;

    // R12
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sram_we_o && sram_oe_o));

    // R3
    ack_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lb_req_i |=> lb_ack_o);

    // R3
    ack_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lb_req_i |=> !lb_ack_o);

    // R1
    csr_no_sram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lb_req_i && !lb_addr_i[SEL_BIT]) |-> (!sram_we_o && !sram_oe_o));

    // R7
    underrun_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lb_req_i && lb_addr_i[SEL_BIT] && !lb_wr_i && fifo_empty_o) |=> (lb_rdata_o == '0));
endmodule

// File: tb/lbus_sram_fifo_tb.sv
`timescale 1ns/1ps
module lbus_sram_fifo_tb_top;
    localparam int TB_PTR_W = 4;
    localparam int TB_DEPTH = 1 << TB_PTR_W;
    localparam int TB_AW    = TB_PTR_W + 1;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        lb_req = 1'b0, lb_wr = 1'b0;
    logic [22:0] lb_addr = '0;
    logic [31:0] lb_wdata = '0;
    logic        lb_ack;
    logic [31:0] lb_rdata;
    logic [TB_AW-1:0] sram_addr;
    logic [31:0] sram_wdata, sram_rdata;
    logic        sram_we, sram_oe;
    logic [TB_PTR_W:0] fcount;
    logic        fempty, ffull;

    always #10 clk = ~clk;

    lbus_sram_fifo #(.PTR_W(TB_PTR_W), .MEM_AW(TB_AW)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni),
        .lb_req_i(lb_req), .lb_wr_i(lb_wr), .lb_addr_i(lb_addr), .lb_wdata_i(lb_wdata),
        .lb_ack_o(lb_ack), .lb_rdata_o(lb_rdata),
        .sram_addr_o(sram_addr), .sram_wdata_o(sram_wdata),
        .sram_we_o(sram_we), .sram_oe_o(sram_oe), .sram_rdata_i(sram_rdata),
        .fifo_count_o(fcount), .fifo_empty_o(fempty), .fifo_full_o(ffull)
    );

    // behavioural synchronous SRAM
    logic [31:0] mem [1 << TB_AW];
    always @(posedge clk) begin
        if (sram_we) mem[sram_addr] <= sram_wdata;
        if (sram_oe) sram_rdata <= mem[sram_addr];
    end

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    // reference queue model
    logic [31:0] m_q [TB_DEPTH];
    int m_head = 0, m_tail = 0, m_cnt = 0;
    // pending beat awaiting its acknowledge
    bit p_req = 1'b0, p_chk = 1'b0;
    logic [31:0] p_data = '0;
    string p_tag = "R11";

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] status_of(input int c);
        logic [31:0] s = '0;
        s[TB_PTR_W:0] = c[TB_PTR_W:0];
        s[30] = (c == TB_DEPTH);
        s[31] = (c == 0);
        return s;
    endfunction

    function automatic logic [22:0] fifo_addr(input int r);
        return {1'b1, r[19:0], 2'b00};
    endfunction

    function automatic logic [22:0] csr_addr(input int idx, input int junk);
        return {1'b0, junk[15:0], idx[3:0], 2'b00};
    endfunction

    task automatic step(input bit req, input bit wr, input logic [22:0] addr,
                        input logic [31:0] wd, input string tag);
        bit is_fifo, push, pop;
        logic [31:0] rexp;
        @(negedge clk);
        chk(lb_ack === p_req, p_tag, "ack (R3)", {31'b0, lb_ack}, {31'b0, p_req});
        if (p_chk) chk(lb_rdata === p_data, p_tag, "rdata", lb_rdata, p_data);
        chk(fcount === (TB_PTR_W+1)'(m_cnt), p_tag, "count", 32'(fcount), 32'(m_cnt));
        chk(fempty === (m_cnt == 0) && ffull === (m_cnt == TB_DEPTH), p_tag, "empty/full",
            {30'b0, fempty, ffull}, {30'b0, m_cnt == 0, m_cnt == TB_DEPTH});
        lb_req = req; lb_wr = wr; lb_addr = addr; lb_wdata = wd;
        #1;
        is_fifo = req && addr[22];
        push = is_fifo && wr && (m_cnt < TB_DEPTH);
        pop  = is_fifo && !wr && (m_cnt > 0);
        chk(sram_we === push, tag, "sram_we", {31'b0, sram_we}, {31'b0, push});
        chk(sram_oe === pop, tag, "sram_oe", {31'b0, sram_oe}, {31'b0, pop});
        chk(!(sram_we && sram_oe), "R12", "strobe overlap", {30'b0, sram_we, sram_oe}, 32'd0);
        if (push) chk(sram_wdata === wd, tag, "sram_wdata", sram_wdata, wd);
        rexp = '0;
        if (pop) rexp = m_q[m_head];
        else if (req && !addr[22] && !wr && addr[5:2] == 4'd0) rexp = status_of(m_cnt);
        p_req = req; p_chk = req && !wr; p_data = rexp; p_tag = tag;
        if (push) begin m_q[m_tail] = wd; m_tail = (m_tail + 1) % TB_DEPTH; m_cnt++; end
        if (pop)  begin m_head = (m_head + 1) % TB_DEPTH; m_cnt--; end
        if (req && !addr[22] && wr && addr[5:2] == 4'd1 && wd[0]) begin
            m_head = 0; m_tail = 0; m_cnt = 0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(lb_ack === 1'b0 && fempty === 1'b1 && fcount === '0, "R11", "reset state",
            {lb_ack, fempty, 25'b0, fcount}, {1'b0, 1'b1, 30'b0});
        rst_ni = 1'b1;

        // R2, R4: fill through scattered window addresses, back to back (R3)
        for (int i = 0; i < TB_DEPTH; i++)
            step(1, 1, fifo_addr(i * 9973 + 5), 32'hA000_0000 + i, "R4");
        // R6: overrun
        step(1, 1, fifo_addr(77), 32'hDEAD_BEEF, "R6");
        // R8: status read while full, plus an unused index
        step(1, 0, csr_addr(0, 3), '0, "R8");
        step(1, 0, csr_addr(7, 0), '0, "R8");
        // R1: register write to status index has no FIFO effect
        step(1, 1, csr_addr(0, 0), 32'hFFFF_FFFF, "R1");
        // R5, R2: drain in order at varied addresses
        for (int i = 0; i < TB_DEPTH; i++)
            step(1, 0, fifo_addr(i * 31), '0, "R5");
        // R7: underrun twice
        step(1, 0, fifo_addr(1), '0, "R7");
        step(1, 0, fifo_addr(2), '0, "R7");
        step(0, 0, '0, '0, "R3");
        step(1, 0, csr_addr(0, 0), '0, "R8");
        // R10: cross the pointer wrap
        for (int i = 0; i < 10; i++) step(1, 1, fifo_addr(i), 32'hB000_0000 + i, "R10");
        for (int i = 0; i < 10; i++) step(1, 0, fifo_addr(i), '0, "R10");
        for (int i = 0; i < 12; i++) step(1, 1, fifo_addr(i), 32'hC000_0000 + i, "R10");
        for (int i = 0; i < 6; i++)  step(1, 0, fifo_addr(i), '0, "R10");
        // R9: clear bit low has no effect, high empties
        step(1, 1, csr_addr(1, 0), 32'hFFFF_FFFE, "R9");
        step(1, 0, csr_addr(0, 0), '0, "R9");
        step(1, 1, csr_addr(2, 0), 32'h0000_0001, "R9");
        step(1, 1, csr_addr(1, 0), 32'h0000_0001, "R9");
        step(1, 0, csr_addr(0, 0), '0, "R9");
        step(1, 0, fifo_addr(3), '0, "R9");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom % 100);
            if (r < 45)      step(1, 1, fifo_addr(int'($urandom)), $urandom, "R4");
            else if (r < 85) step(1, 0, fifo_addr(int'($urandom)), '0, "R5");
            else if (r < 93) step(1, 0, csr_addr(0, int'($urandom)), '0, "R8");
            else if (r < 99) step(0, 0, '0, '0, "R3");
            else             step(1, 1, csr_addr(1, 0), 32'h1, "R9");
        end
        step(0, 0, '0, '0, "R3");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule